// File: doc/BRIEF.md
# History-Rollback Reorder Buffer

This block keeps the in-flight instructions of an out-of-order core in a circular queue, in the order the decoder sees them. When an instruction is decoded, it takes a slot at the tail. The slot stores the number of the destination register and the value that register held before the instruction overwrote it. Execution units report finished work by slot tag, and they may do so in any order. The oldest slot leaves from the head only after its completion mark is set, and at most one slot leaves per cycle. Retirement touches nothing else, because the register file already holds the new value.

When the core must discard speculative work, it pulses `squash`. The buffer then unwinds every slot that has not retired, one slot per cycle, starting with the youngest. For each slot it drives the saved old value onto a restore port that the register file writes. Because the walk goes from youngest to oldest, the value a register held before all discarded work is the last one written. Results that have already retired are never touched. While the walk runs, no new slot is handed out.

Top module: `hist_rob`

## Requirements
- R1: After reset the buffer is empty (`rob_empty`=1), `alloc_ready`=1, and `retire_valid` and `rest_valid` are both 0.
- R2: Each accepted allocation returns `alloc_tag` equal to the slot index at the tail. Tags run 0, 1, ... DEPTH-1 and then wrap to 0.
- R3: With DEPTH live slots, `alloc_ready` is 0 and an `alloc_valid` request is ignored: its slot never retires or restores.
- R4: `retire_valid` is high in a cycle exactly when the head slot is live and marked complete and no squash or unwind is in progress. `retire_tag` is then the head index. One slot retires per rising edge, in allocation order.
- R5: Completions may arrive in any order. A completed slot behind an incomplete head does not retire.
- R6: A squash with live slots starts an unwind in the next cycle. Each cycle, `rest_valid`=1 with `rest_reg`/`rest_data` holding the destination and old value of the youngest remaining slot, until the buffer is empty.
- R7: Slots that retired before a squash are never presented on the restore port.
- R8: `alloc_ready` is 0 in the cycle `squash` is high and throughout the unwind, and it returns to 1 once the buffer is empty.
- R9: A completion whose tag names a slot that is not live is ignored.
- R10: A squash while the buffer is empty produces no restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Decoder requests a slot |
| alloc_dest | input | AW | Destination register of the new instruction |
| alloc_old | input | DW | Value of that register before the instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot handed out |
| cmpl_valid | input | 1 | An execution unit reports completion |
| cmpl_tag | input | log2(DEPTH) | Tag of the completed slot |
| squash | input | 1 | Discard all slots that have not retired |
| retire_valid | output | 1 | Head slot retires at the next edge |
| retire_tag | output | log2(DEPTH) | Tag of the retiring slot |
| retire_dest | output | AW | Destination register of the retiring slot |
| rest_valid | output | 1 | Register-file restore write this cycle |
| rest_reg | output | AW | Register to restore |
| rest_data | output | DW | Old value to write back |
| rob_empty | output | 1 | No live slots |

## Verification
A completion registered at a rising edge raises `retire_valid` for the cycle that follows, and the slot leaves at the next edge. The restore stream begins in the cycle after the edge that samples `squash`, and it moves one slot per edge. `alloc_ready` and `alloc_tag` settle in the same cycle as the inputs that drive them. The bench drives inputs just after a rising edge. A monitor samples the retire and restore ports at the falling edge, in the cycle each result is due, and compares it with the head of a queue of expected tags that the driver fills before it applies the triggering stimulus. Any result that is missing, extra or out of order therefore shows up as a miscompare.

// File: rtl/rob_pkg.sv
package rob_pkg;
   typedef enum logic {
      RB_RUN    = 1'b0,
      RB_UNWIND = 1'b1
   } rb_mode_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
   parameter int PW      = 4,
   parameter bit CAN_DEC = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [PW-1:0] ptr
);
   logic [PW-1:0] nxt;

   generate
      if (CAN_DEC) begin : g_updown
         always_comb begin
            nxt = ptr;
            if (inc)      nxt = ptr + 1'b1;
            else if (dec) nxt = ptr - 1'b1;
         end
         // R6
         step_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec && !inc) |=> ptr == $past(ptr) - 1'b1);
      end else begin : g_up
         always_comb nxt = inc ? ptr + 1'b1 : ptr;
         // R4
         head_fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n) !dec);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= nxt;
   end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
   parameter int DEPTH = 8,
   parameter int AW    = 5,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_dest,
   input  logic [DW-1:0] wr_old,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          ret_en,
   input  logic [IW-1:0] ret_idx,
   input  logic          kill_en,
   input  logic [IW-1:0] kill_idx,
   input  logic [IW-1:0] top_idx,
   output logic          head_done,
   output logic [AW-1:0] head_dest,
   output logic [AW-1:0] top_dest,
   output logic [DW-1:0] top_old
);
   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] done_q;
   logic [AW-1:0]    dest_q [DEPTH];
   logic [DW-1:0]    old_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         done_q  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && wr_idx == IW'(i)) begin
               valid_q[i] <= 1'b1;
               done_q[i]  <= 1'b0;
            end else if ((ret_en && ret_idx == IW'(i)) || (kill_en && kill_idx == IW'(i))) begin
               valid_q[i] <= 1'b0;
               done_q[i]  <= 1'b0;
            end else if (set_en && set_idx == IW'(i) && valid_q[i]) begin
               done_q[i]  <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (wr_en && wr_idx == IW'(i)) begin
            dest_q[i] <= wr_dest;
            old_q[i]  <= wr_old;
         end
      end
   end

   assign head_done = done_q[ret_idx] & valid_q[ret_idx];
   assign head_dest = dest_q[ret_idx];
   assign top_dest  = dest_q[top_idx];
   assign top_old   = old_q[top_idx];

   // R9
   dead_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !valid_q[set_idx]) |=> !done_q[$past(set_idx)]);
   // R4
   done_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q & ~valid_q) == '0);
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
   import rob_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic squash,
   input  logic empty,
   input  logic last,
   output logic unwind
);
   rb_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= RB_RUN;
      else begin
         case (mode_q)
            RB_RUN:    if (squash && !empty) mode_q <= RB_UNWIND;
            RB_UNWIND: if (last)             mode_q <= RB_RUN;
            default:                         mode_q <= RB_RUN;
         endcase
      end
   end

   assign unwind = (mode_q == RB_UNWIND);

   // R6
   unwind_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unwind |-> !empty);
   // R10
   empty_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unwind && squash && empty) |=> !unwind);
endmodule

// File: rtl/hist_rob.sv
module hist_rob #(
   parameter int DEPTH = 8,
   parameter int AW    = 5,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH),
   localparam int PW   = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_valid,
   input  logic [AW-1:0] alloc_dest,
   input  logic [DW-1:0] alloc_old,
   output logic          alloc_ready,
   output logic [IW-1:0] alloc_tag,
   input  logic          cmpl_valid,
   input  logic [IW-1:0] cmpl_tag,
   input  logic          squash,
   output logic          retire_valid,
   output logic [IW-1:0] retire_tag,
   output logic [AW-1:0] retire_dest,
   output logic          rest_valid,
   output logic [AW-1:0] rest_reg,
   output logic [DW-1:0] rest_data,
   output logic          rob_empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("hist_rob: DEPTH must be a power of two, at least 2");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("hist_rob: AW and DW must be positive");
      end
   endgenerate

   logic [PW-1:0] head_p, tail_p, tail_m1, count;
   logic          full, unwind, alloc_fire, head_done, last;

   assign tail_m1   = tail_p - 1'b1;
   assign count     = tail_p - head_p;
   assign rob_empty = (count == '0);
   assign full      = (count == PW'(DEPTH));
   assign last      = (tail_m1 == head_p);

   assign alloc_ready  = !full && !unwind && !squash;
   assign alloc_fire   = alloc_valid && alloc_ready;
   assign alloc_tag    = tail_p[IW-1:0];
   assign retire_valid = !rob_empty && head_done && !unwind && !squash;
   assign retire_tag   = head_p[IW-1:0];
   assign rest_valid   = unwind;

   rob_ptr #(.PW(PW), .CAN_DEC(1'b0)) u_head (
      .clk(clk), .rst_n(rst_n), .inc(retire_valid), .dec(1'b0), .ptr(head_p));

   rob_ptr #(.PW(PW), .CAN_DEC(1'b1)) u_tail (
      .clk(clk), .rst_n(rst_n), .inc(alloc_fire), .dec(rest_valid), .ptr(tail_p));

   rob_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(alloc_fire), .wr_idx(tail_p[IW-1:0]), .wr_dest(alloc_dest), .wr_old(alloc_old),
      .set_en(cmpl_valid && !unwind), .set_idx(cmpl_tag),
      .ret_en(retire_valid), .ret_idx(head_p[IW-1:0]),
      .kill_en(rest_valid), .kill_idx(tail_m1[IW-1:0]),
      .top_idx(tail_m1[IW-1:0]),
      .head_done(head_done), .head_dest(retire_dest),
      .top_dest(rest_reg), .top_old(rest_data));

   rob_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .squash(squash), .empty(rob_empty),
      .last(last), .unwind(unwind));

   // R3
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= PW'(DEPTH));
   // R8
   walk_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rest_valid |-> !alloc_ready);
   // R7
   retire_not_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> !rest_valid);
   // R2
   alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && !retire_valid) |=> count == $past(count) + 1'b1);
endmodule

// File: tb/tb_hist_rob.sv
module tb_hist_rob;
   localparam int DEPTH = 8;
   localparam int AW    = 5;
   localparam int DW    = 32;
   localparam int IW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_valid = 1'b0;
   logic [AW-1:0] alloc_dest = '0;
   logic [DW-1:0] alloc_old = '0;
   logic          alloc_ready;
   logic [IW-1:0] alloc_tag;
   logic          cmpl_valid = 1'b0;
   logic [IW-1:0] cmpl_tag = '0;
   logic          squash = 1'b0;
   logic          retire_valid;
   logic [IW-1:0] retire_tag;
   logic [AW-1:0] retire_dest;
   logic          rest_valid;
   logic [AW-1:0] rest_reg;
   logic [DW-1:0] rest_data;
   logic          rob_empty;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int exp_ret[$];
   int exp_rest[$];
   logic [AW-1:0] m_dest [DEPTH];
   logic [DW-1:0] m_old  [DEPTH];

   always #10 clk = ~clk;

   hist_rob #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // monitor: pops expected items as the design presents them
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (retire_valid) begin
            if (exp_ret.size() == 0) chk("R4 unexpected retire", 64'(retire_tag), 64'hFFFF);
            else begin
               int t;
               t = exp_ret.pop_front();
               chk("R4 retire tag", 64'(retire_tag), 64'(t));
               chk("R4 retire dest", 64'(retire_dest), 64'(m_dest[t]));
            end
         end
         if (rest_valid) begin
            if (exp_rest.size() == 0) chk("R6 unexpected restore", 64'(rest_reg), 64'hFFFF);
            else begin
               int t;
               t = exp_rest.pop_front();
               chk("R6 restore reg", 64'(rest_reg), 64'(m_dest[t]));
               chk("R6 restore data", 64'(rest_data), 64'(m_old[t]));
            end
         end
      end
   end

   task automatic do_alloc(input logic [AW-1:0] d, input logic [DW-1:0] o, input int exp_tag);
      alloc_valid = 1'b1; alloc_dest = d; alloc_old = o;
      #2;
      chk("R2 ready", 64'(alloc_ready), 64'd1);
      chk("R2 tag", 64'(alloc_tag), 64'(exp_tag));
      m_dest[exp_tag] = d; m_old[exp_tag] = o;
      tick();
      alloc_valid = 1'b0;
   endtask

   task automatic do_cmpl(input int t);
      cmpl_valid = 1'b1; cmpl_tag = IW'(t);
      tick();
      cmpl_valid = 1'b0;
   endtask

   task automatic do_squash();
      squash = 1'b1;
      #2;
      chk("R8 ready during squash", 64'(alloc_ready), 64'd0);
      tick();
      squash = 1'b0;
      for (int k = 0; k < 3 * DEPTH && !rob_empty; k++) begin
         #2;
         chk("R8 ready during unwind", 64'(alloc_ready), 64'd0);
         tick();
      end
      #2;
      chk("R8 empty after unwind", 64'(rob_empty), 64'd1);
      chk("R8 ready after unwind", 64'(alloc_ready), 64'd1);
      chk("R6 all restores seen", 64'(exp_rest.size()), 64'd0);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      // R1 reset state
      chk("R1 empty", 64'(rob_empty), 64'd1);
      chk("R1 ready", 64'(alloc_ready), 64'd1);
      chk("R1 retire", 64'(retire_valid), 64'd0);
      chk("R1 restore", 64'(rest_valid), 64'd0);
      rst_n = 1'b1;
      tick();

      // R2 sequential tags
      do_alloc(5'd1, 32'hA000_0001, 0);
      do_alloc(5'd2, 32'hA000_0002, 1);
      do_alloc(5'd3, 32'hA000_0003, 2);

      // R5 out-of-order completion does not retire past an incomplete head
      do_cmpl(2);
      #2 chk("R5 no retire after tag2", 64'(retire_valid), 64'd0);
      do_cmpl(1);
      #2 chk("R5 no retire after tag1", 64'(retire_valid), 64'd0);
      exp_ret.push_back(0); exp_ret.push_back(1); exp_ret.push_back(2);
      do_cmpl(0);
      #2 chk("R4 retire due", 64'(retire_valid), 64'd1);
      tick(); tick(); tick();
      chk("R4 all retired", 64'(exp_ret.size()), 64'd0);
      chk("R4 empty", 64'(rob_empty), 64'd1);

      // R9 completion of a dead slot
      do_cmpl(5);
      #2 chk("R9 no retire", 64'(retire_valid), 64'd0);
      chk("R9 still empty", 64'(rob_empty), 64'd1);

      // R2 wrap and R3 full
      for (int k = 0; k < DEPTH; k++) begin
         int t;
         t = (3 + k) % DEPTH;
         do_alloc(AW'(4 + k), 32'hB000_0000 + DW'(k), t);
      end
      #2 chk("R9 dead completion left no mark", 64'(retire_valid), 64'd0);
      chk("R3 ready low when full", 64'(alloc_ready), 64'd0);
      alloc_valid = 1'b1; alloc_dest = 5'd31; alloc_old = 32'hDEAD_BEEF;
      tick();
      alloc_valid = 1'b0;
      #2 chk("R3 still full", 64'(alloc_ready), 64'd0);

      // R7 retire tag 3, then squash the rest
      exp_ret.push_back(3);
      do_cmpl(3);
      tick();
      chk("R7 retired before squash", 64'(exp_ret.size()), 64'd0);
      for (int k = 0; k < DEPTH - 1; k++) exp_rest.push_back((2 - k + DEPTH) % DEPTH);
      do_squash();

      // R10 squash on empty
      squash = 1'b1;
      tick();
      squash = 1'b0;
      #2 chk("R10 no restore", 64'(rest_valid), 64'd0);
      chk("R10 still empty", 64'(rob_empty), 64'd1);
      tick();

      // R2 tags resume after unwind
      do_alloc(5'd9, 32'hC000_0009, 4);
      do_alloc(5'd10, 32'hC000_000A, 5);
      do_cmpl(5);
      #2 chk("R5 younger done, head not", 64'(retire_valid), 64'd0);
      exp_ret.push_back(4); exp_ret.push_back(5);
      do_cmpl(4);
      tick(); tick();
      chk("R4 final retires", 64'(exp_ret.size()), 64'd0);
      chk("R4 final empty", 64'(rob_empty), 64'd1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule